// File: doc/BRIEF.md
# Sync Polarity Normalizer and Vertical Interval Separator

This block is the sampled-digital front end of a horizontal line-lock loop. It takes one raw sync input, which may be separate horizontal sync or TTL composite sync of either polarity. The input is sampled on a fast system clock, resynchronized and filtered for glitches. The block works out the input's active level from its duty cycle and then emits a one-clock pulse on the leading edge of each horizontal sync. That pulse goes to a downstream phase comparator.

Duty cycle is the single sorting rule. A pulse whose width stays under a quarter of the line period is a horizontal sync. A wider active pulse inside a composite stream marks the vertical interval. The block raises an extracted-vertical level for that interval and a phase-comparator inhibit level. A controller can also force the inhibit level on. Leading edges that arrive well before a full line has elapsed, such as half-line equalizing and serration edges, are dropped so that the comparator sees one clean pulse per line.

The outputs are plain event and level pins with no valid/ready stream. The pulse cannot be back-pressured, and a consumer that misses it loses that line.

Top module: `hsep_sync_separator`

## Requirements
- R1: While reset is held, h_pulse, vsync_ext and pll_inhibit are low (with inhibit_in low) and polarity reads 0.
- R2: After lock, polarity is 0 when the high level is the short one (4·high width < period) and 1 when the low level is the short one (4·low width < period).
- R3: Once locked, h_pulse is high for exactly one clock per line. Consecutive pulses are spaced by exactly the input line period, because each pulse is taken from the leading edge of the active pulse (rising for polarity 0, falling for polarity 1).
- R4: Any level held for fewer than MIN_W clocks is ignored and produces no pulse. A level held for exactly MIN_W clocks is accepted.
- R5: h_pulse stays low until a polarity has been seen on POL_AGREE consecutive lines. An established polarity changes only after POL_AGREE consecutive lines vote for the other one.
- R6: A leading edge that arrives less than 3/4 of the line reference after the last accepted pulse is dropped. Half-line equalizing and serration edges therefore never reach h_pulse.
- R7: vsync_ext rises while an active pulse is longer than a quarter of the line reference, provided that pulse is no longer than half of it. It falls at the end of a later active pulse no wider than a quarter of the reference, and it is held low while an active pulse exceeds half the reference.
- R8: pll_inhibit is high exactly when vsync_ext or inhibit_in is high.
- R9: After a missing pulse (gap longer than 1.5 times the line reference), the line reference is kept, so the following lines still each give one pulse.
- R10: While inhibit_in is high, the line reference is cleared and no edge is held off, so half-line edges are passed until the reference is relearned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Raw asynchronous sync, separate or composite, either polarity |
| inhibit_in | input | 1 | Controller request to block phase comparison, active high |
| h_pulse | output | 1 | One-clock pulse per accepted horizontal leading edge |
| vsync_ext | output | 1 | Extracted vertical interval level |
| pll_inhibit | output | 1 | Phase-comparator inhibit level |
| polarity | output | 1 | Detected active level: 0 high-active, 1 low-active |

## Verification
The bench builds the block with MIN_W = 4, CNT_W = 12 and POL_AGREE = 4. With these values, lines of only 32 to 100 clocks reach every decision: polarity lock and reversal, the 3/4 holdoff, and the quarter-line and half-line duty thresholds. A whole composite vertical interval with equalizing and broad pulses runs in a few hundred clocks. The small MIN_W lets the glitch filter be tested on both sides of its limit with widths of 3 and 4 clocks.

// File: rtl/hsep_pkg.sv
package hsep_pkg;
  typedef enum logic {POL_POS = 1'b0, POL_NEG = 1'b1} pol_e;
  typedef enum logic [1:0] {CAND_NONE = 2'd0, CAND_POS = 2'd1, CAND_NEG = 2'd2} cand_e;
endpackage

// File: rtl/hsep_input_cond.sv
// Two-flop resynchronizer followed by a run-length glitch filter.
module hsep_input_cond #(
  parameter int MIN_W = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_raw,
  output logic lvl,
  output logic rise,
  output logic fall
);
  localparam int DG_W = (MIN_W > 1) ? $clog2(MIN_W) : 1;

  logic [1:0]      meta_q;
  logic            lvl_q, lvl_d_q;
  logic [DG_W-1:0] dg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q  <= '0;
      lvl_q   <= 1'b0;
      lvl_d_q <= 1'b0;
      dg_q    <= '0;
    end else begin
      meta_q  <= {meta_q[0], sync_raw};
      lvl_d_q <= lvl_q;
      if (meta_q[1] != lvl_q) begin
        // new level must persist MIN_W samples before it is taken
        if (dg_q == DG_W'(MIN_W - 1)) begin
          lvl_q <= meta_q[1];
          dg_q  <= '0;
        end else begin
          dg_q <= dg_q + 1'b1;
        end
      end else begin
        dg_q <= '0;
      end
    end
  end

  assign lvl  = lvl_q;
  assign rise = lvl_q & ~lvl_d_q;
  assign fall = ~lvl_q & lvl_d_q;
endmodule

// File: rtl/hsep_polarity_judge.sv
// Per-line duty vote on the filtered level; polarity changes after a streak.
module hsep_polarity_judge
  import hsep_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int POL_AGREE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic fall,
  input  logic vsync,
  input  logic over_wide,
  output pol_e polarity,
  output logic pol_valid,
  output logic pol_chg
);
  localparam int             AG_W    = $clog2(POL_AGREE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] run_q, hi_q;
  logic [1:0]       edges_q;
  logic             skip_q;
  cand_e            cand, cand_q;
  logic [AG_W-1:0]  streak_q, streak_nx;
  pol_e             pol_q, cand_pol;
  logic             valid_q, chg_q;

  logic [CNT_W:0]   per;
  logic [CNT_W+1:0] per_x, hi4, lo4;
  logic             eval, vote, same_now, commit;

  assign per   = {1'b0, hi_q} + {1'b0, run_q};
  assign per_x = {1'b0, per};
  assign hi4   = {hi_q, 2'b00};
  assign lo4   = {run_q, 2'b00};

  always_comb begin
    cand = CAND_NONE;
    if (hi4 < per_x)      cand = CAND_POS;
    else if (lo4 < per_x) cand = CAND_NEG;
  end

  assign cand_pol  = (cand == CAND_NEG) ? POL_NEG : POL_POS;
  assign eval      = rise && (edges_q == 2'd2);
  assign vote      = eval && !vsync && !skip_q;
  assign same_now  = valid_q && (cand_pol == pol_q);
  assign streak_nx = (streak_q != '0 && cand == cand_q) ? streak_q + 1'b1 : AG_W'(1);
  assign commit    = (streak_nx == AG_W'(POL_AGREE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= '0;
      hi_q     <= '0;
      edges_q  <= '0;
      skip_q   <= 1'b0;
      cand_q   <= CAND_NONE;
      streak_q <= '0;
      pol_q    <= POL_POS;
      valid_q  <= 1'b0;
      chg_q    <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (rise || fall)           run_q <= CNT_W'(1);
      else if (run_q != CNT_MAX)  run_q <= run_q + 1'b1;
      if (fall) hi_q <= run_q;
      if ((rise || fall) && edges_q != 2'd2) edges_q <= edges_q + 1'b1;

      if (over_wide)  skip_q <= 1'b0;
      else if (vsync) skip_q <= 1'b1;
      else if (eval)  skip_q <= 1'b0;

      if (vote) begin
        if (cand == CAND_NONE || same_now) begin
          streak_q <= '0;
        end else if (commit) begin
          pol_q    <= cand_pol;
          valid_q  <= 1'b1;
          chg_q    <= 1'b1;
          streak_q <= '0;
        end else begin
          cand_q   <= cand;
          streak_q <= streak_nx;
        end
      end
    end
  end

  assign polarity  = pol_q;
  assign pol_valid = valid_q;
  assign pol_chg   = chg_q;
endmodule

// File: rtl/hsep_line_gate.sv
// Holdoff gating of leading edges and duty-based vertical extraction.
module hsep_line_gate
  import hsep_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise,
  input  logic fall,
  input  pol_e polarity,
  input  logic pol_valid,
  input  logic pol_chg,
  input  logic ref_clr,
  output logic h_pulse,
  output logic vsync,
  output logic over_wide
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] since_q, ref_q, act_q, holdoff;
  logic             have_prev_q, hp_q, vs_q;
  logic             lead, trail, active, accept, upd_ok;
  logic [CNT_W:0]   ref_slack;
  logic [CNT_W+1:0] act4, ref_x, ref2_x;

  assign lead      = (polarity == POL_NEG) ? fall : rise;
  assign trail     = (polarity == POL_NEG) ? rise : fall;
  assign active    = lvl ^ (polarity == POL_NEG);
  assign holdoff   = ref_q - (ref_q >> 2);
  assign ref_slack = {1'b0, ref_q} + {2'b00, ref_q[CNT_W-1:1]};
  assign accept    = lead && pol_valid && (since_q >= holdoff);
  assign upd_ok    = have_prev_q && (since_q != CNT_MAX) &&
                     ((ref_q == '0) || ({1'b0, since_q} <= ref_slack));
  assign act4      = {act_q, 2'b00};
  assign ref_x     = {2'b00, ref_q};
  assign ref2_x    = {1'b0, ref_q, 1'b0};
  assign over_wide = active && pol_valid && (act4 > ref2_x);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q     <= CNT_MAX;
      ref_q       <= '0;
      have_prev_q <= 1'b0;
      act_q       <= '0;
      hp_q        <= 1'b0;
      vs_q        <= 1'b0;
    end else begin
      hp_q <= accept;
      if (accept)                  since_q <= CNT_W'(1);
      else if (since_q != CNT_MAX) since_q <= since_q + 1'b1;

      if (ref_clr) begin
        ref_q       <= '0;
        have_prev_q <= 1'b0;
      end else if (accept) begin
        have_prev_q <= 1'b1;
        if (upd_ok) ref_q <= since_q;
      end

      if (!active)               act_q <= '0;
      else if (act_q != CNT_MAX) act_q <= act_q + 1'b1;

      if (pol_chg || !pol_valid || over_wide)
        vs_q <= 1'b0;
      else if (active && ref_q != '0 && act4 > ref_x)
        vs_q <= 1'b1;
      else if (trail && act4 <= ref_x)
        vs_q <= 1'b0;
    end
  end

  assign h_pulse = hp_q;
  assign vsync   = vs_q;
endmodule

// File: rtl/hsep_sync_separator.sv
module hsep_sync_separator
  import hsep_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MIN_W     = 70,
  parameter int POL_AGREE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic inhibit_in,
  output logic h_pulse,
  output logic vsync_ext,
  output logic pll_inhibit,
  output logic polarity
);
  logic lvl, rise, fall;
  pol_e pol_w;
  logic pol_valid, pol_chg, vs_w, over_w;

  hsep_input_cond #(.MIN_W(MIN_W)) u_cond (
    .clk(clk), .rst_n(rst_n), .sync_raw(sync_in),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  hsep_polarity_judge #(.CNT_W(CNT_W), .POL_AGREE(POL_AGREE)) u_judge (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .vsync(vs_w), .over_wide(over_w),
    .polarity(pol_w), .pol_valid(pol_valid), .pol_chg(pol_chg)
  );

  hsep_line_gate #(.CNT_W(CNT_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall),
    .polarity(pol_w), .pol_valid(pol_valid), .pol_chg(pol_chg),
    .ref_clr(inhibit_in | pol_chg),
    .h_pulse(h_pulse), .vsync(vs_w), .over_wide(over_w)
  );

  assign vsync_ext   = vs_w;
  assign pll_inhibit = vs_w | inhibit_in;
  assign polarity    = logic'(pol_w);
endmodule

// File: rtl/hsep_sync_separator_chk.sv
module hsep_sync_separator_chk (
  input logic clk,
  input logic rst_n,
  input logic inhibit_in,
  input logic h_pulse,
  input logic vsync_ext,
  input logic pll_inhibit,
  input logic polarity,
  input logic pol_valid
);
  // R3
  h_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_pulse |=> !h_pulse);

  // R5
  no_pulse_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_pulse |-> pol_valid);

  // R5
  pol_change_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(polarity) |-> pol_valid);

  // R7
  vsync_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_ext |-> pol_valid);

  // R8
  inhibit_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_in || vsync_ext) |-> pll_inhibit);

  // R8
  inhibit_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inhibit_in && !vsync_ext) |-> !pll_inhibit);
endmodule

bind hsep_sync_separator hsep_sync_separator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inhibit_in(inhibit_in), .h_pulse(h_pulse),
  .vsync_ext(vsync_ext), .pll_inhibit(pll_inhibit), .polarity(polarity),
  .pol_valid(pol_valid)
);

// File: tb/hsep_sync_separator_tb.sv
`timescale 1ns/1ps
module hsep_sync_separator_tb;
  logic clk = 1'b0, rst_n = 1'b0, sync_in = 1'b0, inhibit_in = 1'b0;
  logic h_pulse, vsync_ext, pll_inhibit, polarity;

  always #4 clk = ~clk;

  hsep_sync_separator #(.CNT_W(12), .MIN_W(4), .POL_AGREE(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .inhibit_in(inhibit_in),
    .h_pulse(h_pulse), .vsync_ext(vsync_ext), .pll_inhibit(pll_inhibit),
    .polarity(polarity)
  );

  // stimulus table: polarity, line period, active width; expected polarity and spacing follow
  localparam int VEC_N = 5;
  localparam int V_POL [VEC_N] = '{0, 1, 0, 1, 0};
  localparam int V_PER [VEC_N] = '{64, 64, 100, 48, 80};
  localparam int V_WID [VEC_N] = '{6, 6, 20, 4, 19};

  int n_chk = 0, n_fail = 0;
  int cyc = 0, last_cyc = -1, last_int = 0, pulse_cnt = 0;
  int min_int = 1000000, max_int = 0;

  always @(posedge clk) begin
    #2;
    cyc++;
    if (h_pulse) begin
      if (last_cyc >= 0) begin
        last_int = cyc - last_cyc;
        if (last_int < min_int) min_int = last_int;
        if (last_int > max_int) max_int = last_int;
      end
      last_cyc = cyc;
      pulse_cnt++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clr_stats();
    pulse_cnt = 0;
    min_int   = 1000000;
    max_int   = 0;
  endtask

  task automatic seg(input logic v, input int n);
    sync_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic line(input int pol, input int per, input int w);
    seg(pol != 0 ? 1'b0 : 1'b1, w);
    seg(pol != 0 ? 1'b1 : 1'b0, per - w);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sync_in = 1'b0; inhibit_in = 1'b0;
    repeat (5) @(negedge clk);
    last_cyc = -1;
    clr_stats();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "h_pulse in reset", int'(h_pulse), 0);
    check("R1", "vsync_ext in reset", int'(vsync_ext), 0);
    check("R1", "pll_inhibit in reset", int'(pll_inhibit), 0);
    check("R1", "polarity in reset", int'(polarity), 0);

    // R5 no pulse before lock
    do_reset();
    for (int l = 0; l < 3; l++) line(0, 64, 6);
    check("R5", "pulses before lock", pulse_cnt, 0);

    // table walk: R2 polarity, R3 spacing, R4 width at MIN_W (48/4 entry)
    for (int v = 0; v < VEC_N; v++) begin
      do_reset();
      for (int l = 0; l < 8; l++) line(V_POL[v], V_PER[v], V_WID[v]);
      clr_stats();
      for (int l = 0; l < 6; l++) line(V_POL[v], V_PER[v], V_WID[v]);
      check("R3", "pulses per 6 lines", pulse_cnt, 6);
      check("R3", "min spacing", min_int, V_PER[v]);
      check("R3", "max spacing", max_int, V_PER[v]);
      check("R2", "polarity", int'(polarity), V_POL[v]);
    end

    // R4 glitch shorter than MIN_W
    do_reset();
    for (int l = 0; l < 8; l++) line(0, 64, 6);
    clr_stats();
    for (int l = 0; l < 2; l++) begin
      seg(1'b1, 6); seg(1'b0, 20); seg(1'b1, 3); seg(1'b0, 35);
    end
    for (int l = 0; l < 2; l++) line(0, 64, 6);
    check("R4", "pulses with glitches", pulse_cnt, 4);
    check("R4", "min spacing with glitches", min_int, 64);

    // R5 polarity reversal needs a streak; R7 over-wide pulse is not vertical
    for (int l = 0; l < 2; l++) line(1, 64, 6);
    check("R5", "polarity after 2 reversed lines", int'(polarity), 0);
    check("R7", "vsync on over-wide pulse", int'(vsync_ext), 0);
    for (int l = 0; l < 8; l++) line(1, 64, 6);
    clr_stats();
    for (int l = 0; l < 4; l++) line(1, 64, 6);
    check("R5", "polarity after reversal", int'(polarity), 1);
    check("R5", "pulses after reversal", pulse_cnt, 4);
    check("R5", "spacing after reversal", min_int, 64);

    // R6 and R7 composite vertical interval
    do_reset();
    for (int l = 0; l < 10; l++) line(0, 64, 6);
    clr_stats();
    for (int h = 0; h < 6; h++) line(0, 32, 4);
    for (int h = 0; h < 4; h++) line(0, 32, 26);
    check("R7", "vsync in broad pulses", int'(vsync_ext), 1);
    check("R8", "inhibit in broad pulses", int'(pll_inhibit), 1);
    for (int h = 0; h < 2; h++) line(0, 32, 26);
    for (int h = 0; h < 6; h++) line(0, 32, 4);
    for (int l = 0; l < 6; l++) line(0, 64, 6);
    check("R6", "pulses over composite field", pulse_cnt, 15);
    check("R6", "min spacing over composite", min_int, 64);
    check("R6", "max spacing over composite", max_int, 64);
    check("R7", "vsync after equalizing", int'(vsync_ext), 0);
    check("R2", "polarity kept through vertical", int'(polarity), 0);

    // R9 missing pulse
    clr_stats();
    seg(1'b0, 64);
    for (int l = 0; l < 6; l++) line(0, 64, 6);
    check("R9", "pulses after gap", pulse_cnt, 6);
    check("R9", "gap spacing", max_int, 128);
    check("R9", "spacing after gap", last_int, 64);

    // R8 and R10 controller inhibit
    inhibit_in = 1'b1;
    @(negedge clk);
    check("R8", "pll_inhibit forced", int'(pll_inhibit), 1);
    clr_stats();
    for (int h = 0; h < 4; h++) line(0, 32, 4);
    check("R10", "half-line pulses under inhibit", pulse_cnt, 4);
    check("R10", "half-line spacing under inhibit", min_int, 32);
    inhibit_in = 1'b0;
    @(negedge clk);
    check("R8", "pll_inhibit released", int'(pll_inhibit), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule